// File: doc/BRIEF.md
# T1 Extended Superframe Framing-Bit Inserter

This block sits in the transmit path of a T1 line and fills in the overhead bit at the head of each 193-bit frame. Payload arrives one bit per clock, and a strobe marks the cycle that holds the overhead position of a frame. The block counts frames modulo 24 to follow the extended superframe. In each overhead slot it writes one of three things, chosen by the frame number: a bit of the six-bit alignment word, a bit of the 4 kbit/s maintenance data link, or a bit of the CRC-6 check value. All other bits pass through unchanged, one cycle later.

The CRC-6 is accumulated over the whole superframe, with each overhead position counted as a one. The result goes out in the CRC slots of the superframe that follows. The data-link bits normally come from an external serial input. While the loss-of-sync input is high, the block sends a fixed sixteen-bit alarm word on the data link instead. A frame-number output and a superframe-start pulse line up with the output stream so that downstream logic can see where the overhead bits fall.

Top module: `t1_esf_fbit_gen`

## Requirements
- R1: When `fbit_stb` is low, `tx_bit` one cycle later equals the `pay_bit` value that was present at that edge.
- R2: `frame_idx` reads 0 after reset. On every `fbit_stb` it takes the number of the frame being started: 1 after reset, then counting up to 24 and wrapping back to 1. It holds its value between strobes. It changes on the same edge that registers the overhead bit.
- R3: `sf_start` is high for exactly the one output cycle that carries the overhead bit of frame 1, and is low at all other times.
- R4: The overhead bits of frames 4, 8, 12, 16, 20 and 24 are 0, 0, 1, 0, 1, 1, in that order.
- R5: The overhead bits of frames 2, 6, 10, 14, 18 and 22 carry the check bits C1 to C6, in that order. C1 is bit 5 (the MSB) of the stored remainder and C6 is bit 0.
- R6: The check remainder r[5:0] starts at 0 at the first strobe after reset. For every input bit b it updates as follows: f = r[5] XOR b, r shifts left by one, and r is XORed with 6'b000011 when f is 1 (polynomial x^6+x+1). It runs over all 4632 bits of a superframe, starting with the frame 1 overhead position. When the next frame-1 strobe arrives, the remainder is stored for sending and the calculation restarts. The superframe sent first after reset therefore carries all-zero check bits.
- R7: With `los` low, the overhead bits of odd frames (1, 3, ..., 23) equal `dl_bit` sampled at that frame's strobe.
- R8: With `los` high, the odd-frame overhead bits carry the word 16'hFF00, MSB first, which is eight ones followed by eight zeros. The position in the word advances by one for each data-link slot sent while `los` is high, and only then. It starts at 0 after reset and is not reset at superframe boundaries.
- R9: The `pay_bit` value at a strobe cycle has no effect: it changes neither the overhead bit sent nor the check value, which treats that position as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fbit_stb | input | 1 | High on the cycle holding a frame's overhead position |
| pay_bit | input | 1 | Serial input bit (payload; ignored under the strobe) |
| dl_bit | input | 1 | External data-link bit, taken at odd-frame strobes |
| los | input | 1 | Loss of sync; selects the alarm word on the data link |
| tx_bit | output | 1 | Serial output with overhead inserted, one cycle latency |
| frame_idx | output | 5 | Number (1..24) of the frame currently on the output, 0 before the first |
| sf_start | output | 1 | Pulse aligned with the frame 1 overhead bit on the output |

## Verification
The main function is exercised over four back-to-back superframes. The first has all-zero payload, which shows the all-zero check word that follows reset. The second has alternating payload, which gives a known non-trivial remainder and exercises the alternating data-link input. The third has pseudo-random payload, with random values placed under the strobe as well; a wrong remainder here separates a design that folds those values into the check from one that treats the position as one. Loss of sync is raised for the first half of the third superframe and held through the whole fourth, so the alarm word must continue from position 6 and wrap past position 15 instead of restarting at the boundary.

// File: rtl/esf_pkg.sv
package esf_pkg;
    localparam int FRAMES       = 24;
    localparam int FRAME_BITS   = 193;
    localparam int IDX_W        = $clog2(FRAMES + 1);
    localparam int CRC_W        = 6;
    localparam int ALARM_W      = 16;
    localparam int ALARM_IDX_W  = $clog2(ALARM_W);
    localparam int FAS_W        = 6;

    localparam logic [CRC_W-1:0]   CRC_POLY   = 6'b000011;
    localparam logic [FAS_W-1:0]   FAS_WORD   = 6'b001011;
    localparam logic [ALARM_W-1:0] ALARM_WORD = 16'hFF00;

    // One serial step of the check remainder, MSB-first feedback form.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                  input logic b);
        logic fb;
        fb = r[CRC_W-1] ^ b;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    typedef enum logic [1:0] {
        SLOT_DL  = 2'd0,
        SLOT_CRC = 2'd1,
        SLOT_FAS = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/esf_frame_seq.sv
module esf_frame_seq #(
    parameter int FRAMES = esf_pkg::FRAMES,
    parameter int IDX_W  = esf_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fbit_stb,
    output logic [IDX_W-1:0] cur_idx,
    output logic             sf_boundary,
    output logic [IDX_W-1:0] frame_idx,
    output logic             sf_start
);
    localparam logic [IDX_W-1:0] FIRST = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(FRAMES);

    typedef struct packed {
        logic [IDX_W-1:0] nxt;
        logic [IDX_W-1:0] frame;
        logic             sfs;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sfs = 1'b0;
        if (fbit_stb) begin
            s_d.frame = s_q.nxt;
            s_d.sfs   = (s_q.nxt == FIRST);
            s_d.nxt   = (s_q.nxt == LAST) ? FIRST : s_q.nxt + FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.nxt   <= FIRST;
            s_q.frame <= '0;
            s_q.sfs   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_idx     = s_q.nxt;
    assign sf_boundary = fbit_stb && (s_q.nxt == FIRST);
    assign frame_idx   = s_q.frame;
    assign sf_start    = s_q.sfs;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx <= LAST); // R2
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fbit_stb |=> $stable(frame_idx)); // R2
    AST_SF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start |-> frame_idx == FIRST); // R3
endmodule

// File: rtl/esf_crc6.sv
module esf_crc6 #(
    parameter int CRC_W = esf_pkg::CRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fbit_stb,
    input  logic             sf_boundary,
    input  logic             pay_bit,
    output logic [CRC_W-1:0] sent_crc
);
    typedef struct packed {
        logic             seen;
        logic [CRC_W-1:0] acc;
        logic [CRC_W-1:0] sent;
    } crc_t;

    crc_t c_d, c_q;
    logic eff_bit;

    // Overhead positions enter the calculation as ones.
    assign eff_bit = fbit_stb ? 1'b1 : pay_bit;

    always_comb begin
        c_d = c_q;
        if (sf_boundary) begin
            c_d.seen = 1'b1;
            c_d.sent = c_q.acc;
            c_d.acc  = esf_pkg::crc_step('0, eff_bit);
        end else if (c_q.seen) begin
            c_d.acc  = esf_pkg::crc_step(c_q.acc, eff_bit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sent_crc = c_q.sent;

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_boundary |=> $stable(sent_crc)); // R6
endmodule

// File: rtl/esf_dl_src.sv
module esf_dl_src #(
    parameter int ALARM_W     = esf_pkg::ALARM_W,
    parameter int ALARM_IDX_W = esf_pkg::ALARM_IDX_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dl_slot,
    input  logic los,
    input  logic dl_bit,
    output logic dl_out
);
    localparam logic [ALARM_W-1:0] WORD = esf_pkg::ALARM_WORD;

    typedef struct packed {
        logic [ALARM_IDX_W-1:0] pos;
    } dl_t;

    dl_t d_d, d_q;
    logic alarm_bit;

    assign alarm_bit = WORD[ALARM_IDX_W'(ALARM_W - 1) - d_q.pos];

    always_comb begin
        d_d = d_q;
        if (dl_slot && los) begin
            d_d.pos = d_q.pos + ALARM_IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign dl_out = los ? alarm_bit : dl_bit;

    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(dl_slot && los) |=> $stable(d_q.pos)); // R8
endmodule

// File: rtl/t1_esf_fbit_gen.sv
module t1_esf_fbit_gen #(
    parameter int FRAMES = esf_pkg::FRAMES,
    parameter int IDX_W  = esf_pkg::IDX_W,
    parameter int CRC_W  = esf_pkg::CRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fbit_stb,
    input  logic             pay_bit,
    input  logic             dl_bit,
    input  logic             los,
    output logic             tx_bit,
    output logic [IDX_W-1:0] frame_idx,
    output logic             sf_start
);
    import esf_pkg::*;

    logic [IDX_W-1:0] cur_idx;
    logic             sf_boundary;
    logic [CRC_W-1:0] sent_crc;
    logic             dl_slot;
    logic             dl_out;
    slot_kind_e       kind;
    logic [2:0]       grp;
    logic             oh_bit;

    typedef struct packed {
        logic tx;
    } out_t;

    out_t o_d, o_q;

    esf_frame_seq #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fbit_stb    (fbit_stb),
        .cur_idx     (cur_idx),
        .sf_boundary (sf_boundary),
        .frame_idx   (frame_idx),
        .sf_start    (sf_start)
    );

    esf_crc6 #(.CRC_W(CRC_W)) u_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .fbit_stb    (fbit_stb),
        .sf_boundary (sf_boundary),
        .pay_bit     (pay_bit),
        .sent_crc    (sent_crc)
    );

    assign dl_slot = fbit_stb && cur_idx[0];

    esf_dl_src u_dl (
        .clk     (clk),
        .rst_n   (rst_n),
        .dl_slot (dl_slot),
        .los     (los),
        .dl_bit  (dl_bit),
        .dl_out  (dl_out)
    );

    // Slot decode: odd frames = data link, multiples of 4 = alignment, rest = check.
    always_comb begin
        if (cur_idx[0])            kind = SLOT_DL;
        else if (cur_idx[1] == 1'b0) kind = SLOT_FAS;
        else                        kind = SLOT_CRC;
        grp = 3'(cur_idx >> 2);
        case (kind)
            SLOT_DL:  oh_bit = dl_out;
            SLOT_FAS: oh_bit = FAS_WORD[3'(FAS_W) - grp];
            default:  oh_bit = sent_crc[3'(CRC_W - 1) - grp];
        endcase
    end

    always_comb begin
        o_d    = o_q;
        o_d.tx = fbit_stb ? oh_bit : pay_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tx_bit = o_q.tx;

    AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !fbit_stb |=> tx_bit == $past(pay_bit)); // R1
    AST_SF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start |=> !sf_start); // R3
endmodule

// File: tb/t1_esf_fbit_gen_tb.sv
module t1_esf_fbit_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fbit_stb = 1'b0;
    logic       pay_bit = 1'b0;
    logic       dl_bit = 1'b0;
    logic       los = 1'b0;
    logic       tx_bit;
    logic [4:0] frame_idx;
    logic       sf_start;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    int         m_nxt = 1;
    logic [5:0] m_acc = 6'd0;
    logic [5:0] m_sent = 6'd0;
    int         m_apos = 0;
    logic [15:0] rng = 16'hACE1;

    always #5 clk = ~clk;

    t1_esf_fbit_gen u_dut (
        .clk(clk), .rst_n(rst_n), .fbit_stb(fbit_stb), .pay_bit(pay_bit),
        .dl_bit(dl_bit), .los(los), .tx_bit(tx_bit),
        .frame_idx(frame_idx), .sf_start(sf_start)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_step(input logic [5:0] r, input logic b);
        logic f;
        f = r[5] ^ b;
        r = {r[4:0], 1'b0};
        if (f) r = r ^ 6'b000011;
        return r;
    endfunction

    function automatic logic next_rand();
        rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
        return rng[0];
    endfunction

    // pat: 0 zeros, 1 alternating, 2 pseudo-random; lmode: 0 off, 1 first 12 frames, 2 all
    task automatic run_sf(input int pat, input int lmode);
        for (int f = 1; f <= 24; f++) begin
            for (int b = 0; b < 193; b++) begin
                logic fp, d, dl, l, e;
                fp = (b == 0);
                case (pat)
                    0: d = 1'b0;
                    1: d = b[0];
                    default: d = next_rand();
                endcase
                dl = f[1];
                l  = (lmode == 2) || (lmode == 1 && f <= 12);
                @(negedge clk);
                fbit_stb = fp; pay_bit = d; dl_bit = dl; los = l;
                // reference
                if (fp) begin
                    if (m_nxt % 2 == 1) begin
                        if (l) begin
                            e = (m_apos < 8);
                            m_apos = (m_apos + 1) % 16;
                        end else e = dl;
                    end else if (m_nxt % 4 == 0) begin
                        e = 6'b001011 >> (6 - m_nxt / 4);
                    end else begin
                        e = m_sent >> (5 - (m_nxt - 2) / 4);
                    end
                    if (m_nxt == 1) begin
                        m_sent = m_acc;
                        m_acc = ref_step(6'd0, 1'b1);
                    end else m_acc = ref_step(m_acc, 1'b1);
                end else begin
                    e = d;
                    m_acc = ref_step(m_acc, d);
                end
                @(posedge clk);
                #1;
                if (!fp) check("R1 payload", tx_bit, e);
                else if (m_nxt % 2 == 1)
                    check(l ? "R8 alarm word" : "R7 data link", tx_bit, e);
                else if (m_nxt % 4 == 0) check("R4 alignment", tx_bit, e);
                else check("R5/R6 check bit (R9 strobe data)", tx_bit, e);
                check("R3 sf_start", sf_start, (fp && m_nxt == 1) ? 1 : 0);
                if (fp) begin
                    check("R2 frame_idx", frame_idx, m_nxt);
                    m_nxt = (m_nxt == 24) ? 1 : m_nxt + 1;
                end
            end
        end
    endtask

    task automatic t_reset();
        #1;
        check("R2 reset frame_idx", frame_idx, 0);
        check("R3 reset sf_start", sf_start, 0);
        check("R1 reset tx_bit", tx_bit, 0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_first_sf_zero_crc();
        // R6: first superframe sends zero check bits
        run_sf(0, 0);
    endtask

    task automatic t_alternating();
        // R5 R6 remainder of the zero superframe, R7 alternating link data
        run_sf(1, 0);
    endtask

    task automatic t_random_los_half();
        // R9 random values under strobe, R8 alarm for frames 1..12
        run_sf(2, 1);
    endtask

    task automatic t_los_wrap();
        // R8 alarm position continues across boundary and wraps
        run_sf(2, 2);
        // trailing frame 1 strobe releases the last remainder (R6)
        run_sf(0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_first_sf_zero_crc();
        t_alternating();
        t_random_los_half();
        t_los_wrap();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule